// File: doc/BRIEF.md
# Five-Pin GPIO Port with Peripheral Pin Override

This block is a small general-purpose I/O port on a byte-wide register bus. It has five pins. For each pin it holds a direction latch and a data latch, drives an output enable and an output value to the pad, and samples the pad level through a two-flop synchronizer. Two registers are visible on the bus: a direction register and a port data register. The three upper bits of each byte are hard-wired.

Two peripherals can take pins away from software. A serial enable turns pin 0 into a transmit output and pin 1 into a receive input. Two oscillator mode inputs can also claim pins. Crystal mode claims pins 3 and 4. External-clock mode claims pin 4 and forwards its raw level as a clock input. While a peripheral owns a pin, the register bits for that pin behave differently. The latches keep their contents, so general-purpose behaviour resumes unchanged when the peripheral lets go of the pin.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset the direction and data latches are 0, every `pin_oe` bit is 0, every `pin_out` bit is 0, and a read of the direction register returns 0.
- R2: The direction register is at bus address 0x0C. Bits 4..0 are read/write, one per pin, with bit i for pin i. Bits 7..5 always read 0, and writes to them are ignored.
- R3: On a pin that no peripheral owns, `pin_oe[i]` equals direction bit i (1 means drive, 0 means input) and `pin_out[i]` equals data latch bit i.
- R4: The port data register is at bus address 0x00. On a pin that no peripheral owns, read bit i returns the data latch when direction bit i is 1, and the synchronized pin level when it is 0. Bits 7..5 read 0.
- R5: A change on `pin_in` appears in reads of the data register after exactly two rising clock edges, and not after one.
- R6: When `ser_en` is 1, pin 0 has `pin_oe`=1 and `pin_out` equal to `ser_txd`, and pin 1 has `pin_oe`=0. `ser_rxd` then carries the synchronized pin 1 level. When `ser_en` is 0, `ser_rxd` is held at 1.
- R7: While `ser_en` is 1, data register read bits 0 and 1 return the synchronized pin levels, whatever the direction bits are.
- R8: `osc_xtal`=1 gives pins 3 and 4 to the oscillator. `osc_extclk`=1 gives pin 4 to it. On an oscillator-owned pin, `pin_oe` and `pin_out` are 0, the pin's bits in both registers read 0, and bus writes leave that pin's direction and data latches unchanged.
- R9: `ext_clk` equals `pin_in[4]` while pin 4 is oscillator-owned, and is 0 otherwise.
- R10: Direction and data latches keep their values through any override. Bus writes to serial-owned bits still update the latches. When the override is removed, R3 and R4 apply again with the stored values.
- R11: A bus read at any address other than 0x00 or 0x0C returns 0, and a write there changes neither latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pin_in | input | 5 | Pad input levels |
| pin_oe | output | 5 | Pad output enables |
| pin_out | output | 5 | Pad output values |
| ser_en | input | 1 | Serial peripheral owns pins 0 and 1 |
| ser_txd | input | 1 | Serial transmit data, driven onto pin 0 |
| ser_rxd | output | 1 | Synchronized pin 1 level for the serial receiver |
| osc_xtal | input | 1 | Crystal oscillator owns pins 3 and 4 |
| osc_extclk | input | 1 | External clock input owns pin 4 |
| ext_clk | output | 1 | Raw pin 4 level when it serves as a clock input |

## Verification
The hardest case to reach from the ports is a bus write made while a pin is owned by the oscillator. Whether it was ignored cannot be seen during the override, because the owned bits read as 0. The bench therefore writes the inverse of the stored values under every mode combination, removes the override, and then reads both registers back and looks at `pin_out` to show which bits changed. The pad sweep walks all 32 pin patterns under every direction value and every mode. Each pattern is allowed two edges to pass the synchronizer before it is read.

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NPINS = 5,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 8'h0C,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 8'h00,
  parameter int TX_PIN = 0,
  parameter int RX_PIN = 1,
  parameter int XTAL_PIN = 3,
  parameter int CLK_PIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_out,
  input  logic              ser_en,
  input  logic              ser_txd,
  output logic              ser_rxd,
  input  logic              osc_xtal,
  input  logic              osc_extclk,
  output logic              ext_clk
);
  localparam int PAD = DATA_W - NPINS;

  logic [NPINS-1:0] dir_q, dat_q, sync1_q, sync2_q;
  logic [NPINS-1:0] osc_own, ser_own, rd_dir, rd_dat, wmask;

  always_comb begin
    osc_own = '0;
    if (osc_xtal) begin
      osc_own[XTAL_PIN] = 1'b1;
      osc_own[CLK_PIN]  = 1'b1;
    end
    if (osc_extclk) osc_own[CLK_PIN] = 1'b1;
    ser_own = '0;
    if (ser_en) begin
      ser_own[TX_PIN] = 1'b1;
      ser_own[RX_PIN] = 1'b1;
    end
  end

  assign wmask = ~osc_own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == DIR_ADDR)
        dir_q <= (dir_q & ~wmask) | (bus_wdata[NPINS-1:0] & wmask);
      if (bus_addr == DAT_ADDR)
        dat_q <= (dat_q & ~wmask) | (bus_wdata[NPINS-1:0] & wmask);
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pin_oe[i]  = osc_own[i] ? 1'b0 :
                        (ser_en && i == TX_PIN) ? 1'b1 :
                        (ser_en && i == RX_PIN) ? 1'b0 : dir_q[i];
    assign pin_out[i] = osc_own[i] ? 1'b0 :
                        (ser_en && i == TX_PIN) ? ser_txd : dat_q[i];
    assign rd_dat[i]  = osc_own[i] ? 1'b0 :
                        ser_own[i] ? sync2_q[i] :
                        dir_q[i] ? dat_q[i] : sync2_q[i];
    assign rd_dir[i]  = osc_own[i] ? 1'b0 : dir_q[i];
  end

  always_comb begin
    if (bus_addr == DIR_ADDR)      bus_rdata = {{PAD{1'b0}}, rd_dir};
    else if (bus_addr == DAT_ADDR) bus_rdata = {{PAD{1'b0}}, rd_dat};
    else                           bus_rdata = '0;
  end

  assign ser_rxd = ser_en ? sync2_q[RX_PIN] : 1'b1;
  assign ext_clk = osc_own[CLK_PIN] ? pin_in[CLK_PIN] : 1'b0;
endmodule

// File: rtl/gpio_port_ovr_chk.sv
module gpio_port_ovr_chk #(
  parameter logic [7:0] DIR_ADDR = 8'h0C
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_rdata,
  input logic [4:0] pin_oe,
  input logic [4:0] pin_out,
  input logic       ser_en,
  input logic       ser_txd,
  input logic       ser_rxd,
  input logic       osc_xtal,
  input logic       osc_extclk,
  input logic [4:0] dir_q
);
  // R2
  dir_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == DIR_ADDR) |-> (bus_rdata[7:5] == 3'b000));
  // R6
  ser_pin_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> (pin_oe[0] && !pin_oe[1] && pin_out[0] == ser_txd));
  // R6
  rxd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |-> ser_rxd);
  // R8
  osc_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_xtal |-> (pin_oe[4:3] == 2'b00 && pin_out[4:3] == 2'b00));
  // R8
  osc_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DIR_ADDR && osc_xtal) |=> (dir_q[4:3] == $past(dir_q[4:3])));
  // R8
  extclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DIR_ADDR && osc_extclk) |=> (dir_q[4] == $past(dir_q[4])));
endmodule

bind gpio_port_ovr gpio_port_ovr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .pin_oe(pin_oe), .pin_out(pin_out),
  .ser_en(ser_en), .ser_txd(ser_txd), .ser_rxd(ser_rxd),
  .osc_xtal(osc_xtal), .osc_extclk(osc_extclk), .dir_q(dir_q)
);

// File: tb/sim_gpio_port_ovr.sv
`timescale 1ns/1ps
module sim_gpio_port_ovr;
  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic bus_wr = 0;
  logic [4:0] pin_in = 0, pin_oe, pin_out;
  logic ser_en = 0, ser_txd = 0, ser_rxd, osc_xtal = 0, osc_extclk = 0, ext_clk;
  int total = 0, fails = 0;
  bit done = 0;
  logic [4:0] mdir = 0, mdat = 0;

  always #5 clk = ~clk;

  gpio_port_ovr u0 (.*);

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  function automatic logic [4:0] own_osc(logic xt, logic ek);
    return (xt ? 5'b11000 : 5'b0) | (ek ? 5'b10000 : 5'b0);
  endfunction

  initial begin
    logic [7:0] v;
    logic [4:0] oo, so, eoe, eout, erd;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1
    rd(8'h0C, v); chk("R1 dir read", v, 0);
    chk("R1 oe", pin_oe, 0);
    chk("R1 out", pin_out, 0);
    chk("R6 rxd idle", ser_rxd, 1);

    // R2 every byte into the direction register
    for (int d = 0; d < 256; d++) begin
      wr(8'h0C, 8'(d));
      rd(8'h0C, v);
      chk("R2 dir readback", v, d & 8'h1F);
      chk("R3 oe follows dir", pin_oe, d & 5'h1F);
    end

    // R5 synchronizer latency
    wr(8'h0C, 0); pin_in = 0;
    repeat (2) @(negedge clk);
    pin_in = 5'h1F;
    @(negedge clk); rd(8'h00, v); chk("R5 one edge", v, 0);
    @(negedge clk); rd(8'h00, v); chk("R5 two edges", v, 8'h1F);

    // R11 unmapped address
    wr(8'h0C, 8'h0A); wr(8'h00, 8'h15);
    wr(8'h05, 8'hFF);
    rd(8'h05, v); chk("R11 unmapped read", v, 0);
    rd(8'h0C, v); chk("R11 dir unchanged", v, 8'h0A);
    chk("R11 data unchanged", pin_out, 5'h15);

    // mode x direction x pad sweep: R3 R4 R6 R7 R8 R9 R10
    for (int m = 0; m < 8; m++) begin
      for (int dv = 0; dv < 32; dv++) begin
        ser_en = 0; osc_xtal = 0; osc_extclk = 0;
        mdir = 5'(dv); mdat = 5'(dv) ^ 5'h15;
        wr(8'h0C, {3'b111, mdir}); wr(8'h00, {3'b101, mdat});
        ser_en = m[0]; osc_xtal = m[1]; osc_extclk = m[2];
        oo = own_osc(m[1], m[2]);
        so = m[0] ? 5'b00011 : 5'b0;
        for (int p = 0; p < 32; p++) begin
          pin_in = 5'(p); ser_txd = p[2] ^ p[0];
          repeat (2) @(negedge clk);
          eoe = mdir; eout = mdat; erd = (mdir & mdat) | (~mdir & 5'(p));
          if (m[0]) begin
            eoe[0] = 1; eoe[1] = 0; eout[0] = ser_txd;
            erd[1:0] = 2'(p);
          end
          eoe &= ~oo; eout &= ~oo; erd &= ~oo;
          chk("R3 R6 R8 oe", pin_oe, eoe);
          chk("R3 R6 R8 out", pin_out, eout);
          rd(8'h00, v); chk("R4 R7 R8 data read", v, erd);
          rd(8'h0C, v); chk("R2 R8 dir read", v, mdir & ~oo);
          chk("R6 rxd", ser_rxd, m[0] ? p[1] : 1'b1);
          chk("R9 ext_clk", ext_clk, oo[4] ? p[4] : 1'b0);
        end
        // writes under override; owned-by-oscillator bits must hold
        wr(8'h0C, {3'b000, ~mdir}); wr(8'h00, {3'b000, ~mdat});
        mdir = (mdir & oo) | (~mdir & ~oo);
        mdat = (mdat & oo) | (~mdat & ~oo);
        ser_en = 0; osc_xtal = 0; osc_extclk = 0;
        #1;
        rd(8'h0C, v); chk("R8 R10 dir after release", v, mdir);
        chk("R8 R10 data latch after release", pin_out, mdat);
        chk("R10 oe after release", pin_oe, mdir);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule